// File: doc/BRIEF.md
# Validated Static Crossbar Map Loader

This block programs a fixed routing crossbar from a text image held in non-volatile storage. After a start pulse it reads a byte stream, looks for a nine-character ASCII keyword anywhere in the text, and reads the twelve hexadecimal characters right after it as a routing map. Map entry k names the source port whose lanes are passed to destination port k. The crossbar has twelve destination ports and fourteen source ports.

The switch turns on only when all twelve entries are legal hex digits, every value lies below fourteen, and no value is used twice. The block also stops with an error when the stream ends or the 64 KiB byte limit is reached before a full map has been read. A map is loaded once per reset. While the switch is off, every destination lane is held at zero.

Top module: `xbar_map_loader`

## Requirements
- R1: After reset, done, enable and err are 0 and every destination lane is 0.
- R2: Bytes offered before the start pulse are ignored. The keyword search covers only bytes accepted after start, and the keyword may appear at any offset in the text.
- R3: Each of the 12 characters after the keyword is one hex digit, upper or lower case. Character k (counting from 0) sets the source for destination k, so dst_lanes[k*8 +: 8] equals src_lanes[v*8 +: 8] for that value v.
- R4: A map value of 14 or 15 ends the load with err=1 and enable=0.
- R5: A value that repeats an earlier entry ends the load with err=1 and enable=0.
- R6: A character in the map field that is not 0-9, A-F or a-f ends the load with err=1 and enable=0.
- R7: If s_last arrives on a byte before the twelfth digit is accepted, the load ends with err=1 and enable=0.
- R8: Once 65536 bytes have been accepted without a complete map, the load ends with err=1. After 65535 bytes, done is still 0.
- R9: A failed partial keyword match does not hide a real match that overlaps it, for example a repeated first character or a repeated keyword prefix.
- R10: done, and either enable or err, rise on the first clock edge after the byte that decides the result. enable and err are never 1 together. The status then holds until reset, and later start pulses and bytes change neither the status nor the routing.
- R11: While enable is 0, every destination lane is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins the load |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | s_data is valid this cycle |
| s_last | input | 1 | Final byte of the stream |
| done | output | 1 | Load has finished |
| enable | output | 1 | Map passed every check; switch active |
| err | output | 1 | Load failed |
| src_lanes | input | 112 | Source ports, 14 lanes of 8 bits |
| dst_lanes | output | 96 | Destination ports, 12 lanes of 8 bits |

## Verification
The status flags are registered. They change on the clock edge that accepts the deciding byte, which is a digit, an illegal character or a last byte. The bench therefore reads them at the falling edge right after that byte, and in one case also one byte earlier to show they have not risen too soon. The crossbar path is combinational from src_lanes to dst_lanes. The bench changes the source lanes at a falling edge and compares the destination lanes one time step later, within the same cycle.

// File: rtl/xbar_map_loader.sv
module xbar_map_loader #(
  parameter int N_DST     = 12,
  parameter int N_SRC     = 14,
  parameter int LANE_W    = 8,
  parameter int MAX_BYTES = 65536,
  parameter int KW_BYTES  = 9,
  parameter logic [8*KW_BYTES-1:0] KEYWORD = "ROUTEMAP:"
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [7:0]              s_data,
  input  logic                    s_valid,
  input  logic                    s_last,
  output logic                    done,
  output logic                    enable,
  output logic                    err,
  input  logic [N_SRC*LANE_W-1:0] src_lanes,
  output logic [N_DST*LANE_W-1:0] dst_lanes
);
  localparam int SEL_W = 4;
  localparam int CNT_W = $clog2(MAX_BYTES);
  localparam int IDX_W = $clog2(N_DST);
  localparam int WIN_W = 8 * KW_BYTES;

  typedef enum logic [1:0] {ST_IDLE, ST_SEEK, ST_DIGITS, ST_FIN} state_t;

  state_t                st;
  logic [CNT_W-1:0]      cnt;
  logic [IDX_W-1:0]      idx;
  logic [WIN_W-1:0]      window;
  logic [2**SEL_W-1:0]   seen;
  logic [SEL_W-1:0]      map_q [N_DST];

  logic [WIN_W-1:0] win_nxt;
  logic             at_end;
  logic             hex_ok;
  logic [SEL_W-1:0] hex_val;

  assign win_nxt = {window[WIN_W-9:0], s_data};
  assign at_end  = s_last || (cnt == CNT_W'(MAX_BYTES - 1));

  always_comb begin
    hex_ok  = 1'b1;
    hex_val = '0;
    if (s_data >= "0" && s_data <= "9")      hex_val = SEL_W'(s_data - "0");
    else if (s_data >= "A" && s_data <= "F") hex_val = SEL_W'(s_data - "A" + 8'd10);
    else if (s_data >= "a" && s_data <= "f") hex_val = SEL_W'(s_data - "a" + 8'd10);
    else hex_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      window <= '0;
      seen   <= '0;
      done   <= 1'b0;
      enable <= 1'b0;
      err    <= 1'b0;
      for (int i = 0; i < N_DST; i++) map_q[i] <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_SEEK;
          cnt    <= '0;
          window <= '0;
        end
        ST_SEEK: if (s_valid) begin
          cnt    <= cnt + 1'b1;
          window <= win_nxt;
          if (win_nxt == KEYWORD && !at_end) begin
            st  <= ST_DIGITS;
            idx <= '0;
          end else if (at_end) begin
            st   <= ST_FIN;
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        ST_DIGITS: if (s_valid) begin
          cnt <= cnt + 1'b1;
          if (!hex_ok || hex_val >= SEL_W'(N_SRC) || seen[hex_val]) begin
            st   <= ST_FIN;
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            map_q[idx]    <= hex_val;
            seen[hex_val] <= 1'b1;
            if (idx == IDX_W'(N_DST - 1)) begin
              st     <= ST_FIN;
              done   <= 1'b1;
              enable <= 1'b1;
            end else if (at_end) begin
              st   <= ST_FIN;
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_DST; g++) begin : g_route
    assign dst_lanes[g*LANE_W +: LANE_W] =
      enable ? src_lanes[map_q[g]*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/xbar_map_loader_chk.sv
module xbar_map_loader_chk #(
  parameter int DST_W = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             enable,
  input logic             err,
  input logic [DST_W-1:0] dst_lanes
);
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && err));
  assert_flag_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable || err) |-> done);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(enable) && $stable(err)));
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (dst_lanes == '0));
endmodule

bind xbar_map_loader xbar_map_loader_chk #(.DST_W(N_DST*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .enable(enable), .err(err),
  .dst_lanes(dst_lanes)
);

// File: tb/xbar_map_loader_test.sv
module xbar_map_loader_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [7:0]   s_data = '0;
  logic         s_valid = 1'b0;
  logic         s_last = 1'b0;
  logic         done, enable, err;
  logic [111:0] src_lanes = '0;
  logic [95:0]  dst_lanes;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  xbar_map_loader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .done(done), .enable(enable), .err(err),
    .src_lanes(src_lanes), .dst_lanes(dst_lanes)
  );

  localparam int NV = 10;
  localparam bit [255:0] TXT [NV] = '{
    "hdr ROUTEMAP:CAB012345D78 x",
    "RROUTEMAP:cab012345d78",
    "ROUTEMAP:0123456789AB",
    "ROUTEMAP:0123456789AE",
    "ROUTEMAP:0123456789A0",
    "ROUTEMAP:01234G6789AB",
    "ROUTEMAP:012345",
    "no key here",
    "ROUTEROUTEMAP:DCBA98765432",
    "ROUTEMAP:0123456789ABF"
  };
  localparam bit       OK  [NV] = '{1, 1, 1, 0, 0, 0, 0, 0, 1, 1};
  localparam bit [47:0] MAP [NV] = '{
    48'hCAB012345D78, 48'hCAB012345D78, 48'h0123456789AB, 48'h0, 48'h0,
    48'h0, 48'h0, 48'h0, 48'hDCBA98765432, 48'h0123456789AB
  };
  localparam string REQ [NV] = '{"R2/R3", "R3/R9", "R3", "R4", "R5", "R6",
                                 "R7", "R7", "R9", "R10"};

  function automatic int txt_len(bit [255:0] t);
    for (int b = 31; b >= 0; b--) if (t[b*8 +: 8] != 8'h00) return b + 1;
    return 0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; s_valid = 1'b0; s_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, logic last);
    s_data = b; s_valid = 1'b1; s_last = last;
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic send_text(bit [255:0] t, bit with_last);
    int n = txt_len(t);
    for (int j = 0; j < n; j++)
      send_byte(t[(n-1-j)*8 +: 8], with_last && (j == n - 1));
  endtask

  task automatic check_routes(string req, bit [47:0] m);
    for (int j = 0; j < 14; j++) src_lanes[j*8 +: 8] = 8'h40 + 8'(j);
    #1;
    for (int k = 0; k < 12; k++)
      chk(req, dst_lanes[k*8 +: 8], 8'h40 + 8'(m[(11-k)*4 +: 4]));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 done", done, 0);
    chk("R1 enable", enable, 0);
    chk("R1 err", err, 0);
    src_lanes = '1; #1;
    chk("R1 lanes", dst_lanes, 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      pulse_start();
      send_text(TXT[v], 1'b1);
      chk({REQ[v], " done"}, done, 1);
      chk({REQ[v], " enable"}, enable, OK[v]);
      chk({REQ[v], " err"}, err, !OK[v]);
      if (OK[v]) check_routes(REQ[v], MAP[v]);
      else begin
        src_lanes = '1; #1;
        chk("R11 disabled lanes", dst_lanes, 0);
      end
    end

    // R2: a full map offered before start is not seen
    do_reset();
    send_text("ROUTEMAP:0123456789AB", 1'b1);
    chk("R2 no done before start", done, 0);
    pulse_start();
    send_text("qq", 1'b1);
    chk("R2 err", err, 1);
    chk("R2 enable", enable, 0);

    // R10: timing of the deciding byte
    do_reset();
    pulse_start();
    send_text("ROUTEMAP:0123456789A", 1'b0);
    chk("R10 done before final digit", done, 0);
    send_byte("B", 1'b1);
    chk("R10 done after final digit", done, 1);
    chk("R10 enable", enable, 1);

    // R10: a second load attempt changes nothing
    pulse_start();
    send_text("ROUTEMAP:CAB012345D78", 1'b1);
    chk("R10 enable held", enable, 1);
    chk("R10 err held", err, 0);
    check_routes("R10 map held", 48'h0123456789AB);

    // R8: byte limit
    do_reset();
    pulse_start();
    for (int j = 0; j < 65535; j++) send_byte("z", 1'b0);
    chk("R8 done at 65535", done, 0);
    send_byte("z", 1'b0);
    chk("R8 done at limit", done, 1);
    chk("R8 err at limit", err, 1);
    chk("R8 enable", enable, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule